// File: doc/BRIEF.md
# Gated Encoder Rate and Speed Meter

This block turns the count-step stream of one incremental encoder channel into a rate in hertz and a shaft speed in revolutions per minute. A quadrature decoder upstream supplies a single-cycle step strobe and a direction level. A 1 ms tick from a shared time base closes a measurement gate of 20, 100, 500 or 1000 ms. Short gates give fast updates but coarse steps of 50 Hz. Long gates give 1 Hz steps but update slowly.

When a gate closes, the net signed count for that gate is captured and a new gate starts in the same cycle. A single shared sequential divider then works out the rate in two passes. The first pass gives hertz from the count and the gate length. The second pass gives the speed from the rate and a programmable counts-per-revolution value. Both results are published together, with a one-cycle valid strobe. The speed is a signed fixed-point number with 16 fractional bits and is negative when the net motion in the gate was in reverse. A resolution of zero is reported as an error, and the speed is then forced to zero.

Top module: `gated_freq_meter`

## Requirements
- R1: `period_sel` picks the gate length in 1 ms ticks: 2'b00 = 20, 2'b01 = 100, 2'b10 = 500, 2'b11 = 1000. The gate counts only cycles where `tick_ms` is high.
- R2: Each gate produces exactly one `result_valid` pulse. With a constant period, consecutive pulses are spaced by exactly the gate length in `tick_ms` periods.
- R3: `freq_hz` equals |net count| × 1000 / gate length in ms, as an unsigned 32-bit value.
- R4: Every cycle with `step` high adds +1 to the gate's net count when `dir` is 1 and −1 when `dir` is 0. A step in the cycle that closes a gate belongs to the closing gate. No step is lost or counted twice across a boundary.
- R5: `result_valid` is high for one cycle. `freq_hz`, `speed_rpm` and `res_err` change only in that cycle.
- R6: `speed_rpm` equals the truncation of `freq_hz` × 60 × 2^16 / `counts_per_rev`, in two's complement. It is negated when the net count of the gate is negative.
- R7: A gate holding steps in both directions reports the rate and speed of the net difference.
- R8: If `counts_per_rev` is 0 when the gate closes, `res_err` is published as 1 and `speed_rpm` as 0, while `freq_hz` is still valid. A later nonzero value clears `res_err` at the next publication.
- R9: While `rst_n` is low at a clock edge, all outputs return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| step | input | 1 | One count step from the decoder |
| dir | input | 1 | Step direction: 1 forward, 0 reverse |
| period_sel | input | 2 | Gate length select |
| counts_per_rev | input | 16 | Counts per revolution, 1 to 65535 |
| freq_hz | output | 32 | Unsigned rate in Hz |
| speed_rpm | output | 56 | Signed speed in rpm, 16 fractional bits |
| result_valid | output | 1 | One-cycle update strobe |
| res_err | output | 1 | Resolution was zero for the published result |

## Verification
The hardest case to reach is a step that lands in the same cycle as the gate closing. From the ports, the timing of that cycle cannot be seen. The stimulus therefore holds `step` high in every cycle across two whole gates. Each gate then contains exactly one step per clock, including its closing cycle, whatever its phase. A gate whose rate is off by one count in either direction exposes a lost step or a double-counted step.

// File: rtl/gfm_pkg.sv
// Shared types and the gate-length decode for the gated rate meter.
package gfm_pkg;

    localparam int GATE_MS_W = 11;

    typedef enum logic [1:0] {
        GATE_20MS   = 2'b00,
        GATE_100MS  = 2'b01,
        GATE_500MS  = 2'b10,
        GATE_1000MS = 2'b11
    } gate_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FREQ,
        ST_SPEED
    } mtr_state_e;

    // Gate length in milliseconds for a period select code.
    function automatic logic [GATE_MS_W-1:0] gate_ms(input logic [1:0] sel);
        case (gate_sel_e'(sel))
            GATE_20MS:   return GATE_MS_W'(20);
            GATE_100MS:  return GATE_MS_W'(100);
            GATE_500MS:  return GATE_MS_W'(500);
            default:     return GATE_MS_W'(1000);
        endcase
    endfunction

endpackage

// File: rtl/gfm_gate_timer.sv
// Gate timer: counts millisecond ticks and strobes gate_end on the tick
// that completes the selected gate length.
// Assumes tick_ms is a single-cycle strobe. A shorter period selected
// mid-gate closes the gate on the next tick.
module gfm_gate_timer
    import gfm_pkg::*;
#(
    parameter int MS_W = GATE_MS_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic [1:0] period_sel,
    output logic       gate_end
);

    logic [MS_W-1:0] ms_cnt;
    logic [MS_W-1:0] gate_len;

    assign gate_len = MS_W'(gate_ms(period_sel));
    assign gate_end = tick_ms && (ms_cnt >= gate_len - 1'b1);

    // Advance the millisecond count, wrapping at the end of each gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_cnt <= '0;
        end else if (tick_ms) begin
            ms_cnt <= gate_end ? '0 : ms_cnt + 1'b1;
        end
    end

    // R1: the gate counter only moves on a millisecond tick
    p_cnt_idle_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_ms |=> $stable(ms_cnt));

endmodule

// File: rtl/gfm_edge_accum.sv
// Step accumulator: sums signed steps over a gate, captures the total in
// the cycle the gate closes, and restarts from zero in the same cycle.
// Assumes step is a single-cycle strobe qualified by dir (1 = forward).
module gfm_edge_accum #(
    parameter int CNT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    dir,
    input  logic                    gate_end,
    output logic signed [CNT_W-1:0] gate_count,
    output logic                    count_stb
);

    logic signed [CNT_W-1:0] acc;
    logic signed [CNT_W-1:0] delta;

    // Signed contribution of this cycle's step.
    always_comb begin
        if (!step)     delta = '0;
        else if (dir)  delta = CNT_W'(1);
        else           delta = '1;
    end

    // Accumulate steps and hand the gate total over when the gate closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            gate_count <= '0;
            count_stb  <= 1'b0;
        end else begin
            count_stb <= gate_end;
            if (gate_end) begin
                gate_count <= acc + delta;
                acc        <= '0;
            end else begin
                acc <= acc + delta;
            end
        end
    end

    // R4: a new gate starts empty when no step shares the closing cycle
    p_accum_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end && !step |=> acc == '0);

endmodule

// File: rtl/gfm_seq_div.sv
// Restoring divider: one quotient bit per cycle, W cycles per division.
// done pulses for one cycle with the quotient in place. A zero divisor
// yields an all-ones quotient, which the caller must mask.
module gfm_seq_div #(
    parameter int W = 56
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);

    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem;
    logic [W:0]    rem_sh;
    logic [W:0]    diff;
    logic          fits;
    logic [W-1:0]  dsr;
    logic [CW-1:0] bits_left;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        rem_sh = {rem[W-1:0], quotient[W-1]};
        diff   = rem_sh - {1'b0, dsr};
        fits   = !diff[W];
    end

    // Load operands on start, then shift in one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem       <= '0;
            quotient  <= '0;
            dsr       <= '0;
            bits_left <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else if (start) begin
            rem       <= '0;
            quotient  <= dividend;
            dsr       <= divisor;
            bits_left <= CW'(W);
            busy      <= 1'b1;
            done      <= 1'b0;
        end else if (busy) begin
            rem       <= fits ? diff : rem_sh;
            quotient  <= {quotient[W-2:0], fits};
            bits_left <= bits_left - 1'b1;
            if (bits_left == CW'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R2: each division completes with a single done strobe
    p_div_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/gated_freq_meter.sv
// Gated rate and speed meter for one encoder channel.
// Counts net steps over a 20/100/500/1000 ms gate, then reuses one
// sequential divider twice: hertz = |count|*1000/gate_ms, and
// speed = hertz*60*2^16/counts_per_rev, signed by net direction.
// Assumes the gate is longer than two divisions (2*DIV_W+2 cycles).
module gated_freq_meter
    import gfm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int FREQ_W = 32,
    parameter int RES_W  = 16,
    parameter int FRAC_W = 16,
    parameter int MS_W   = GATE_MS_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  tick_ms,
    input  logic                                  step,
    input  logic                                  dir,
    input  logic [1:0]                            period_sel,
    input  logic [RES_W-1:0]                      counts_per_rev,
    output logic [FREQ_W-1:0]                     freq_hz,
    output logic signed [FREQ_W+8+FRAC_W-1:0]     speed_rpm,
    output logic                                  result_valid,
    output logic                                  res_err
);

    localparam int DIV_W    = FREQ_W + 8 + FRAC_W;
    localparam int HZ_SCALE = 1000;
    localparam int SEC_MIN  = 60;

    logic                    gate_end;
    logic signed [CNT_W-1:0] gate_count;
    logic                    count_stb;
    logic [CNT_W-1:0]        mag_now;
    mtr_state_e              state;
    logic                    neg_l;
    logic [RES_W-1:0]        res_l;
    logic [FREQ_W-1:0]       freq_l;
    logic                    div_start;
    logic [DIV_W-1:0]        div_dividend;
    logic [DIV_W-1:0]        div_divisor;
    logic                    div_busy;
    logic                    div_done;
    logic [DIV_W-1:0]        div_quot;

    gfm_gate_timer #(.MS_W(MS_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_ms    (tick_ms),
        .period_sel (period_sel),
        .gate_end   (gate_end)
    );

    gfm_edge_accum #(.CNT_W(CNT_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .dir        (dir),
        .gate_end   (gate_end),
        .gate_count (gate_count),
        .count_stb  (count_stb)
    );

    gfm_seq_div #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quot)
    );

    // Magnitude of the captured gate count.
    assign mag_now = gate_count[CNT_W-1] ? $unsigned(-gate_count) : $unsigned(gate_count);

    // Select divider operands: rate pass from idle, speed pass after it.
    always_comb begin
        div_start = 1'b0;
        if (state == ST_IDLE) begin
            div_start    = count_stb;
            div_dividend = DIV_W'(mag_now) * DIV_W'(HZ_SCALE);
            div_divisor  = DIV_W'(gate_ms(period_sel));
        end else begin
            div_start    = (state == ST_FREQ) && div_done;
            div_dividend = (DIV_W'(div_quot[FREQ_W-1:0]) * DIV_W'(SEC_MIN)) << FRAC_W;
            div_divisor  = DIV_W'(res_l);
        end
    end

    // Sequence the two divisions and publish both results together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            neg_l        <= 1'b0;
            res_l        <= '0;
            freq_l       <= '0;
            freq_hz      <= '0;
            speed_rpm    <= '0;
            result_valid <= 1'b0;
            res_err      <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (count_stb) begin
                        neg_l <= gate_count[CNT_W-1];
                        res_l <= counts_per_rev;
                        state <= ST_FREQ;
                    end
                end
                ST_FREQ: begin
                    if (div_done) begin
                        freq_l <= div_quot[FREQ_W-1:0];
                        state  <= ST_SPEED;
                    end
                end
                ST_SPEED: begin
                    if (div_done) begin
                        freq_hz      <= freq_l;
                        result_valid <= 1'b1;
                        res_err      <= (res_l == '0);
                        if (res_l == '0)
                            speed_rpm <= '0;
                        else if (neg_l)
                            speed_rpm <= -$signed(div_quot);
                        else
                            speed_rpm <= $signed(div_quot);
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a new gate total never arrives while a computation is in flight
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_stb |-> state == ST_IDLE);

    // R5: the update strobe lasts a single cycle
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R5: the rate output moves only together with the strobe
    p_freq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(freq_hz));

    // R6: a reverse speed implies a nonzero rate
    p_sign_needs_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && (speed_rpm < 0) |-> freq_hz != '0);

    // R8: a flagged resolution publishes zero speed
    p_err_zero_speed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && res_err |-> speed_rpm == '0);

endmodule

// File: tb/sim_gated_freq_meter.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario and checks its results.
module sim_gated_freq_meter;

    localparam int TICK_CYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic        step = 1'b0;
    logic        dir = 1'b1;
    logic [1:0]  period_sel = 2'b00;
    logic [15:0] res = 16'd1000;
    logic [31:0]        freq;
    logic signed [55:0] speed;
    logic               valid;
    logic               err;

    int checks = 0;
    int fails  = 0;

    gated_freq_meter u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_ms        (tick_ms),
        .step           (step),
        .dir            (dir),
        .period_sel     (period_sel),
        .counts_per_rev (res),
        .freq_hz        (freq),
        .speed_rpm      (speed),
        .result_valid   (valid),
        .res_err        (err)
    );

    always #2.5 clk = ~clk;

    // Millisecond time base, scaled to TICK_CYC clocks per tick.
    initial begin
        forever begin
            repeat (TICK_CYC - 1) @(negedge clk);
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #900000;
        fails++;
        checks++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ms_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 20;
            2'b01:   return 100;
            2'b10:   return 500;
            default: return 1000;
        endcase
    endfunction

    function automatic longint exp_freq(input longint net, input int p_ms);
        longint m;
        m = (net < 0) ? -net : net;
        return (m * 1000) / p_ms;
    endfunction

    function automatic longint exp_speed(input longint net, input int p_ms, input int r);
        longint s;
        if (r == 0) return 0;
        s = (exp_freq(net, p_ms) * 60 * 65536) / r;
        return (net < 0) ? -s : s;
    endfunction

    task automatic wait_valid();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!valid && n < 60000);
        if (!valid) begin
            checks++;
            fails++;
            $display("FAIL R2 no result pulse actual=0 expected=1");
        end
    endtask

    // One gate with nf forward then nr reverse steps (R1 R3 R4 R6 R7 R8).
    task automatic gate_case(input string tag, input logic [1:0] sel, input int r,
                             input int nf, input int nr);
        longint net;
        int p;
        period_sel = sel;
        res = 16'(r);
        repeat (nf) begin
            dir = 1'b1; step = 1'b1; @(negedge clk);
            step = 1'b0; @(negedge clk);
        end
        repeat (nr) begin
            dir = 1'b0; step = 1'b1; @(negedge clk);
            step = 1'b0; @(negedge clk);
        end
        dir = 1'b1;
        wait_valid();
        net = longint'(nf) - longint'(nr);
        p = ms_of(sel);
        check({tag, " R3 freq"}, longint'(freq), exp_freq(net, p));
        check({tag, " R6 speed"}, longint'(speed), exp_speed(net, p, r));
        check({tag, " R8 err"}, longint'(err), (r == 0) ? 1 : 0);
    endtask

    // Pulse spacing, strobe width and output hold between pulses (R2 R5).
    task automatic interval_case();
        int n;
        int moved;
        logic [31:0] f0;
        period_sel = 2'b00;
        res = 16'd1000;
        n = 0;
        moved = 0;
        f0 = freq;
        @(negedge clk);
        n++;
        check("R5 strobe width", longint'(valid), 0);
        while (!valid && n < 60000) begin
            if (freq !== f0) moved++;
            @(negedge clk);
            n++;
        end
        check("R2 pulse spacing", n, 20 * TICK_CYC);
        check("R5 freq held between pulses", moved, 0);
    endtask

    // A step in every cycle, across the gate boundaries (R4).
    task automatic boundary_case();
        period_sel = 2'b00;
        res = 16'd1000;
        dir = 1'b1;
        step = 1'b1;
        wait_valid();
        wait_valid();
        check("R4 full gate freq", longint'(freq), exp_freq(20 * TICK_CYC, 20));
        check("R4 full gate speed", longint'(speed), exp_speed(20 * TICK_CYC, 20, 1000));
        step = 1'b0;
        wait_valid();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R9 reset freq", longint'(freq), 0);
        check("R9 reset speed", longint'(speed), 0);
        check("R9 reset valid", longint'(valid), 0);
        check("R9 reset err", longint'(err), 0);
        rst_n = 1'b1;
        wait_valid();
        check("R3 idle gate freq", longint'(freq), 0);

        gate_case("R1 20ms fwd", 2'b00, 1000, 100, 0);
        gate_case("R1 100ms rev", 2'b01, 7, 0, 37);
        gate_case("R7 mixed max res", 2'b00, 65535, 50, 20);
        gate_case("R1 500ms unit res", 2'b10, 1, 123, 0);
        gate_case("R1 1000ms rev", 2'b11, 2500, 0, 200);
        gate_case("R8 zero res", 2'b00, 0, 10, 0);
        gate_case("R8 clear", 2'b00, 1000, 0, 0);
        gate_case("R7 net reverse", 2'b00, 360, 15, 40);
        interval_case();
        boundary_case();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule